// File: doc/BRIEF.md
# Floating-Point to Signed Integer Converter

This block turns a binary64 or binary32 floating-point operand into a signed 32-bit or signed 64-bit integer. It can round to nearest, toward zero, toward negative infinity or toward positive infinity. A generic convert-to-long operation takes its rounding direction from a field in the status register. Every conversion refreshes a set of per-operation cause bits and accumulates sticky flag bits in a 32-bit status register. Any result that cannot be represented is replaced by a fixed maximum-positive pattern.

A conversion starts when a value is presented with `in_valid` high. One cycle later the result is registered with a one-cycle `out_valid` pulse, and it stays on the output until the next conversion. Software clears flags, and sets the rounding-mode field, by writing the whole status register through `sr_wr`/`sr_wdata`.

Top module: `f2i_conv`

## Requirements
- R1: `out_valid` pulses high exactly one cycle after each cycle with `in_valid` high and is low otherwise. `out_result` keeps its value through cycles without a conversion.
- R2: Operation codes are 1 = toward zero, 2 = toward negative infinity and 3 = toward positive infinity. `in_long` = 1 gives a 64-bit result. `in_long` = 0 gives a 32-bit result, sign-extended to 64 bits on `out_result`.
- R3: Operation code 0 with a 32-bit destination rounds to nearest, and a value exactly halfway between two integers goes to the even one.
- R4: Operation code 0 with a 64-bit destination rounds to nearest, and a value exactly halfway goes away from zero.
- R5: Operation code 4 always yields a 64-bit result and takes its direction from status bits [1:0]: 0 = nearest with halfway cases away from zero, 1 = toward zero, 2 = toward positive infinity, 3 = toward negative infinity.
- R6: A rounded value above the destination's maximum or below its minimum sets both overflow and invalid (flag and cause). The result becomes 0x7FFF_FFFF_FFFF_FFFF for 64-bit destinations and 0x0000_0000_7FFF_FFFF for 32-bit destinations. -2^31 and -2^63 are in range.
- R7: A NaN operand sets invalid only (flag and cause) and returns the saturation pattern. An infinite operand is out of range and follows R6.
- R8: When rounding discards a nonzero fraction and the result is not invalid, the inexact flag and cause are set. Inexact and overflow cause are never set together.
- R9: Each conversion rewrites the inexact, underflow and overflow causes. It only ORs into the invalid cause and leaves the divide-by-zero cause untouched. Underflow is never raised, because an integer result is never a nonzero value below the smallest normal.
- R10: Flag bits are sticky: a conversion never clears a flag. Only a status write can clear one.
- R11: A status write replaces all 32 bits and takes priority over a conversion's status update in the same cycle. That conversion still uses the old rounding-mode field. Without a write, the mode field never changes.
- R12: The status register has the rounding mode in bits [1:0]. Flags are in bits 2..6 (inexact, underflow, overflow, divide-by-zero, invalid). Causes are in bits 12..16, in the same order.
- R13: With `in_dbl` = 0 the operand is the binary32 value in `in_opnd[31:0]`, and bits [63:32] are ignored.
- R14: After reset, `out_valid` is 0, `out_result` is 0 and the status register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Start a conversion this cycle |
| in_opnd | input | 64 | Floating-point operand bits |
| in_dbl | input | 1 | 1 = binary64 operand, 0 = binary32 in low half |
| in_long | input | 1 | 1 = 64-bit destination, 0 = 32-bit destination |
| in_op | input | 3 | Rounding operation code |
| sr_wr | input | 1 | Write the status register this cycle |
| sr_wdata | input | 32 | Value written to the status register |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_result | output | 64 | Converted integer or saturation pattern |
| out_status | output | 32 | Status register contents |

## Verification
The bench targets halfway values on both destination widths. A design that shares one tie rule would give 3 instead of 2 for 2.5 to a word, or -2 instead of -3 for -2.5 to a long-word. It also drives values right at each range edge: 2147483647.5 rounds up past the word maximum, and -2^31, -2^63 and -2147483648.5 truncated must all stay in range. An off-by-one limit compare would saturate or wrap on these. NaN, infinities, denormals and binary32 operands with junk in the upper half expose overflow wrongly raised for NaN, denormals rounded to zero under ceiling, and the wrong half of the operand being read. Status sequences check that an invalid cause survives a later clean conversion while overflow and inexact causes are refreshed, and that a same-cycle write beats the update.

// File: rtl/f2i_pkg.sv
package f2i_pkg;

    localparam int unsigned XW       = 64;             // long-word width
    localparam int unsigned WW       = 32;             // word width
    localparam int unsigned SRW      = 32;             // status register width
    localparam int unsigned NEXC     = 5;              // exception kinds
    localparam int unsigned RM_LSB   = 0;              // rounding-mode field
    localparam int unsigned FLG_LSB  = 2;              // sticky flags
    localparam int unsigned CAU_LSB  = 12;             // per-operation causes
    localparam int unsigned MANW     = 53;             // significand incl. hidden bit
    localparam int unsigned EXPW     = 13;             // unbiased exponent width
    localparam int unsigned ALW      = 2 * XW;         // integer.fraction window
    localparam int unsigned FRAC_OFF = XW - (MANW - 1);
    localparam int unsigned SHW      = $clog2(ALW);

    // exception bit order inside both the flag and the cause field
    localparam int unsigned EX_NX = 0;
    localparam int unsigned EX_UF = 1;
    localparam int unsigned EX_OF = 2;
    localparam int unsigned EX_DZ = 3;
    localparam int unsigned EX_NV = 4;

    // causes overwritten on each conversion; the rest accumulate
    localparam logic [NEXC-1:0] CAUSE_REFRESH = 5'b00111;

    typedef enum logic [2:0] {
        OP_NEAREST = 3'd0,
        OP_TRUNC   = 3'd1,
        OP_FLOOR   = 3'd2,
        OP_CEIL    = 3'd3,
        OP_CVT_L   = 3'd4
    } conv_op_e;

    typedef enum logic [2:0] {
        RK_EVEN,
        RK_AWAY,
        RK_ZERO,
        RK_DOWN,
        RK_UP
    } rkind_e;

    typedef struct packed {
        logic                   sign;
        logic                   nan;
        logic                   inf;
        logic signed [EXPW-1:0] exp;
        logic [MANW-1:0]        man;
    } unpacked_t;

    typedef struct packed {
        logic          sign;
        logic          nan;
        logic          inf;
        logic          huge;
        logic [XW-1:0] ipart;
        logic          half;
        logic          sticky;
    } aligned_t;

    typedef struct packed {
        logic [XW-1:0]   value;
        logic [NEXC-1:0] exc;
    } conv_res_t;

    function automatic logic long_dest(input logic [2:0] op, input logic lng);
        return lng | (op == OP_CVT_L);
    endfunction

    function automatic rkind_e pick_kind(input logic [2:0] op, input logic lng,
                                         input logic [1:0] rm);
        rkind_e k;
        case (op)
            OP_NEAREST: k = lng ? RK_AWAY : RK_EVEN;
            OP_FLOOR:   k = RK_DOWN;
            OP_CEIL:    k = RK_UP;
            OP_CVT_L: begin
                case (rm)
                    2'd0:    k = RK_AWAY;
                    2'd1:    k = RK_ZERO;
                    2'd2:    k = RK_UP;
                    default: k = RK_DOWN;
                endcase
            end
            default:    k = RK_ZERO;
        endcase
        return k;
    endfunction

    function automatic logic [XW-1:0] sentinel(input logic lng);
        logic [XW-1:0] s;
        if (lng) s = {1'b0, {(XW-1){1'b1}}};
        else     s = {{(XW-WW+1){1'b0}}, {(WW-1){1'b1}}};
        return s;
    endfunction

endpackage

// File: rtl/f2i_unpack.sv
module f2i_unpack
    import f2i_pkg::*;
(
    input  logic [XW-1:0] opnd,
    input  logic          dbl,
    output unpacked_t     u
);
    localparam int unsigned SE = 8;
    localparam int unsigned SF = 23;
    localparam int unsigned SB = 127;
    localparam int unsigned DE = 11;
    localparam int unsigned DF = 52;
    localparam int unsigned DB = 1023;

    unpacked_t us;
    unpacked_t ud;
    logic [SE-1:0] s_ef;
    logic [SF-1:0] s_fr;
    logic [DE-1:0] d_ef;
    logic [DF-1:0] d_fr;

    assign s_ef = opnd[SE+SF-1:SF];
    assign s_fr = opnd[SF-1:0];
    assign d_ef = opnd[DE+DF-1:DF];
    assign d_fr = opnd[DF-1:0];

    always_comb begin
        us.sign = opnd[SE+SF];
        us.nan  = (&s_ef) & (|s_fr);
        us.inf  = (&s_ef) & ~(|s_fr);
        if (s_ef == '0) us.exp = $signed(EXPW'(1)) - $signed(EXPW'(SB));
        else            us.exp = $signed(EXPW'(s_ef)) - $signed(EXPW'(SB));
        us.man  = {(|s_ef), s_fr, {(MANW-1-SF){1'b0}}};

        ud.sign = opnd[DE+DF];
        ud.nan  = (&d_ef) & (|d_fr);
        ud.inf  = (&d_ef) & ~(|d_fr);
        if (d_ef == '0) ud.exp = $signed(EXPW'(1)) - $signed(EXPW'(DB));
        else            ud.exp = $signed(EXPW'(d_ef)) - $signed(EXPW'(DB));
        ud.man  = {(|d_ef), d_fr};

        u = dbl ? ud : us;
    end
endmodule

// File: rtl/f2i_align.sv
module f2i_align
    import f2i_pkg::*;
(
    input  unpacked_t u,
    output aligned_t  a
);
    localparam logic signed [EXPW-1:0] E_LO = EXPW'(-1);
    localparam logic signed [EXPW-1:0] E_HI = EXPW'(XW - 1);

    logic [ALW-1:0] wide;
    logic [SHW-1:0] sh;
    logic           tiny;
    logic [EXPW-1:0] sh_full;

    always_comb begin
        sh_full = u.exp + EXPW'(FRAC_OFF);
        sh      = sh_full[SHW-1:0];
        tiny    = $signed(u.exp) < E_LO;
        wide    = {{(ALW-MANW){1'b0}}, u.man} << sh;

        a.sign = u.sign;
        a.nan  = u.nan;
        a.inf  = u.inf;
        a.huge = $signed(u.exp) > E_HI;
        if (tiny) begin
            a.ipart  = '0;
            a.half   = 1'b0;
            a.sticky = |u.man;
        end else begin
            a.ipart  = wide[ALW-1:XW];
            a.half   = wide[XW-1];
            a.sticky = |wide[XW-2:0];
        end
    end
endmodule

// File: rtl/f2i_round.sv
module f2i_round
    import f2i_pkg::*;
(
    input  aligned_t  a,
    input  rkind_e    kind,
    input  logic      lng,
    output conv_res_t r
);
    localparam logic [XW:0] POS_L = {2'b00, {(XW-1){1'b1}}};
    localparam logic [XW:0] NEG_L = {2'b01, {(XW-1){1'b0}}};
    localparam logic [XW:0] POS_W = {{(XW-WW+2){1'b0}}, {(WW-1){1'b1}}};
    localparam logic [XW:0] NEG_W = {{(XW-WW+1){1'b0}}, 1'b1, {(WW-1){1'b0}}};

    logic          lost;
    logic          inc;
    logic [XW:0]   mag;
    logic [XW-1:0] sval;
    logic          out_rng;
    logic          inval;

    always_comb begin
        lost = a.half | a.sticky;
        case (kind)
            RK_EVEN: inc = a.half & (a.sticky | a.ipart[0]);
            RK_AWAY: inc = a.half;
            RK_DOWN: inc = a.sign & lost;
            RK_UP:   inc = ~a.sign & lost;
            default: inc = 1'b0;
        endcase
        mag = {1'b0, a.ipart} + {{XW{1'b0}}, inc};

        if (a.sign) out_rng = mag > (lng ? NEG_L : NEG_W);
        else        out_rng = mag > (lng ? POS_L : POS_W);
        out_rng = ~a.nan & (out_rng | a.huge | a.inf);
        inval   = out_rng | a.nan;

        sval = a.sign ? (~mag[XW-1:0] + {{(XW-1){1'b0}}, 1'b1}) : mag[XW-1:0];

        if (inval)    r.value = sentinel(lng);
        else if (lng) r.value = sval;
        else          r.value = {{(XW-WW){sval[WW-1]}}, sval[WW-1:0]};

        r.exc        = '0;
        r.exc[EX_NX] = lost & ~inval;
        r.exc[EX_OF] = out_rng;
        r.exc[EX_NV] = inval;
    end
endmodule

// File: rtl/f2i_status.sv
module f2i_status
    import f2i_pkg::*;
#(
    parameter logic [SRW-1:0] RESET_VAL = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr,
    input  logic [SRW-1:0]  wdata,
    input  logic            upd,
    input  logic [NEXC-1:0] exc,
    output logic [SRW-1:0]  sr
);
    logic [SRW-1:0]  sr_q;
    logic [SRW-1:0]  sr_d;
    logic [NEXC-1:0] flg_n;
    logic [NEXC-1:0] cau_n;

    for (genvar gi = 0; gi < NEXC; gi++) begin : g_exc
        assign flg_n[gi] = sr_q[FLG_LSB+gi] | (upd & exc[gi]);
        if (CAUSE_REFRESH[gi]) begin : g_refresh
            assign cau_n[gi] = upd ? exc[gi] : sr_q[CAU_LSB+gi];
        end else begin : g_accum
            assign cau_n[gi] = sr_q[CAU_LSB+gi] | (upd & exc[gi]);
        end
    end

    always_comb begin
        sr_d                    = sr_q;
        sr_d[FLG_LSB +: NEXC]   = flg_n;
        sr_d[CAU_LSB +: NEXC]   = cau_n;
        if (wr) sr_d = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) sr_q <= RESET_VAL;
        else     sr_q <= sr_d;
    end

    assign sr = sr_q;
endmodule

// File: rtl/f2i_conv.sv
module f2i_conv
    import f2i_pkg::*;
#(
    parameter logic [SRW-1:0] SR_RESET = '0
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic [XW-1:0]  in_opnd,
    input  logic           in_dbl,
    input  logic           in_long,
    input  logic [2:0]     in_op,
    input  logic           sr_wr,
    input  logic [SRW-1:0] sr_wdata,
    output logic           out_valid,
    output logic [XW-1:0]  out_result,
    output logic [SRW-1:0] out_status
);
    unpacked_t u;
    aligned_t  a;
    conv_res_t cr;
    rkind_e    kind;
    logic      lng_eff;

    assign lng_eff = long_dest(in_op, in_long);
    assign kind    = pick_kind(in_op, in_long, out_status[RM_LSB +: 2]);

    f2i_unpack u_unpack (.opnd(in_opnd), .dbl(in_dbl), .u(u));
    f2i_align  u_align  (.u(u), .a(a));
    f2i_round  u_round  (.a(a), .kind(kind), .lng(lng_eff), .r(cr));

    f2i_status #(.RESET_VAL(SR_RESET)) u_status (
        .clk   (clk),
        .rst   (rst),
        .wr    (sr_wr),
        .wdata (sr_wdata),
        .upd   (in_valid),
        .exc   (cr.exc),
        .sr    (out_status)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_result <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_result <= cr.value;
        end
    end
endmodule

// File: rtl/f2i_conv_chk.sv
module f2i_conv_chk
    import f2i_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic           in_valid,
    input logic           in_long,
    input logic [2:0]     in_op,
    input logic           sr_wr,
    input logic           out_valid,
    input logic [XW-1:0]  out_result,
    input logic [SRW-1:0] out_status
);
    logic lng_in;
    assign lng_in = long_dest(in_op, in_long);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R1
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid); // R1
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst) !in_valid |=> $stable(out_result)); // R1
    AST_SENTINEL_ON_OVF: assert property (@(posedge clk) disable iff (rst) (out_valid && !$past(sr_wr) && out_status[CAU_LSB+EX_OF]) |-> (out_result == sentinel($past(lng_in)))); // R6
    AST_NX_OF_EXCL: assert property (@(posedge clk) disable iff (rst) (out_valid && !$past(sr_wr)) |-> !(out_status[CAU_LSB+EX_NX] && out_status[CAU_LSB+EX_OF])); // R8
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst) (out_valid && !$past(sr_wr)) |-> !out_status[CAU_LSB+EX_UF]); // R9
    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (rst) !sr_wr |=> (($past(out_status[FLG_LSB +: NEXC]) & ~out_status[FLG_LSB +: NEXC]) == '0)); // R10
    AST_MODE_STABLE: assert property (@(posedge clk) disable iff (rst) !sr_wr |=> $stable(out_status[RM_LSB +: 2])); // R11
endmodule

bind f2i_conv f2i_conv_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_long    (in_long),
    .in_op      (in_op),
    .sr_wr      (sr_wr),
    .out_valid  (out_valid),
    .out_result (out_result),
    .out_status (out_status)
);

// File: tb/f2i_conv_tb.sv
module f2i_conv_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] in_opnd = '0;
    logic        in_dbl = 1'b1;
    logic        in_long = 1'b0;
    logic [2:0]  in_op = '0;
    logic        sr_wr = 1'b0;
    logic [31:0] sr_wdata = '0;
    logic        out_valid;
    logic [63:0] out_result;
    logic [31:0] out_status;

    int    checks = 0;
    int    fails = 0;
    bit    done = 1'b0;
    string cur_tag = "R14";

    // reference model state
    bit          m_ov = 1'b0;
    logic [63:0] m_res = '0;
    logic [31:0] m_sr = '0;
    string       m_tag = "R14";

    always #(CLK_PERIOD/2) clk = ~clk;

    f2i_conv u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_opnd(in_opnd),
        .in_dbl(in_dbl), .in_long(in_long), .in_op(in_op), .sr_wr(sr_wr),
        .sr_wdata(sr_wdata), .out_valid(out_valid), .out_result(out_result),
        .out_status(out_status)
    );

    function automatic logic [63:0] widen(input logic [31:0] s);
        logic [10:0] e;
        if (s[30:23] == 8'd0) return {s[31], 63'd0};
        e = 11'(s[30:23]) + 11'd896;
        return {s[31], e, s[22:0], 29'd0};
    endfunction

    function automatic void ref_conv(input logic [63:0] o, input bit dbl, input bit lng_in,
                                     input int op, input int rm,
                                     output logic [63:0] res, output logic [4:0] ex);
        bit nan, inf, neg, up, lng;
        int kind; // 0 even, 1 zero, 2 down, 3 up, 5 away
        real x, ax, fl, fr, r, rs;
        longint li;
        logic [63:0] sat;
        ex = '0;
        lng = lng_in;
        if (dbl) begin
            nan = (o[62:52] == 11'h7FF) && (o[51:0] != 0);
            inf = (o[62:52] == 11'h7FF) && (o[51:0] == 0);
        end else begin
            nan = (o[30:23] == 8'hFF) && (o[22:0] != 0);
            inf = (o[30:23] == 8'hFF) && (o[22:0] == 0);
        end
        if (op == 4) begin
            lng = 1;
            kind = (rm == 0) ? 5 : (rm == 1) ? 1 : (rm == 2) ? 3 : 2;
        end else if (op == 0) kind = lng ? 5 : 0;
        else if (op >= 1 && op <= 3) kind = op;
        else kind = 1;
        sat = lng ? 64'h7FFF_FFFF_FFFF_FFFF : 64'h0000_0000_7FFF_FFFF;
        if (nan) begin
            res = sat; ex[4] = 1'b1; return;
        end
        if (inf) begin
            res = sat; ex[2] = 1'b1; ex[4] = 1'b1; return;
        end
        x  = dbl ? $bitstoreal(o) : $bitstoreal(widen(o[31:0]));
        neg = x < 0.0;
        ax = neg ? -x : x;
        fl = $floor(ax);
        fr = ax - fl;
        case (kind)
            0: up = (fr > 0.5) || (fr == 0.5 && ((longint'(fl) & 64'sd1) != 0));
            5: up = fr >= 0.5;
            2: up = neg && fr != 0.0;
            3: up = !neg && fr != 0.0;
            default: up = 1'b0;
        endcase
        r  = fl + (up ? 1.0 : 0.0);
        rs = neg ? -r : r;
        if ((lng && (rs >= 9223372036854775808.0 || rs < -9223372036854775808.0)) ||
            (!lng && (rs > 2147483647.0 || rs < -2147483648.0))) begin
            res = sat; ex[2] = 1'b1; ex[4] = 1'b1; return;
        end
        li  = longint'(rs);
        res = lng ? 64'(li) : {{32{li[31]}}, li[31:0]};
        ex[0] = fr != 0.0;
    endfunction

    always @(posedge clk) begin
        logic [63:0] r;
        logic [4:0]  e;
        if (rst) begin
            m_ov = 1'b0; m_res = '0; m_sr = '0; m_tag = "R14";
        end else begin
            m_ov = in_valid;
            e = '0;
            if (in_valid) begin
                ref_conv(in_opnd, in_dbl, in_long, int'(in_op), int'(m_sr[1:0]), r, e);
                m_res = r;
                m_tag = cur_tag;
            end
            if (sr_wr) begin
                m_sr = sr_wdata;
                if (!in_valid) m_tag = cur_tag;
            end else if (in_valid) begin
                for (int i = 0; i < 5; i++) m_sr[2+i] = m_sr[2+i] | e[i];
                for (int i = 0; i < 3; i++) m_sr[12+i] = e[i];
                m_sr[16] = m_sr[16] | e[4];
            end
        end
    end

    task automatic chk(input string tag, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R1", "out_valid", 64'(out_valid), 64'(m_ov));
            chk(m_tag, "out_result", out_result, m_res);
            chk(m_tag, "out_status", 64'(out_status), 64'(m_sr));
        end
    end

    task automatic conv(input logic [63:0] o, input bit dbl, input bit lng,
                        input logic [2:0] op, input string tag);
        in_opnd = o; in_dbl = dbl; in_long = lng; in_op = op; in_valid = 1'b1; cur_tag = tag;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic cd(input real x, input logic [2:0] op, input bit lng, input string tag);
        conv($realtobits(x), 1'b1, lng, op, tag);
    endtask

    task automatic wr_sr(input logic [31:0] d, input string tag);
        sr_wr = 1'b1; sr_wdata = d; cur_tag = tag;
        @(negedge clk);
        sr_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);                       // R14 reset values compared here
        // R2: directed rounding, both widths and signs
        cd(2.7, 3'd1, 0, "R2");  cd(2.7, 3'd2, 0, "R2");  cd(2.7, 3'd3, 0, "R2");
        cd(-2.7, 3'd1, 1, "R2"); cd(-2.7, 3'd2, 1, "R2"); cd(-2.7, 3'd3, 1, "R2");
        cd(-0.3, 3'd1, 0, "R2"); cd(4611686018427387904.0, 3'd1, 1, "R2");
        // R3: ties to even for words
        cd(2.5, 3'd0, 0, "R3");  cd(3.5, 3'd0, 0, "R3");  cd(-2.5, 3'd0, 0, "R3");
        cd(2.4, 3'd0, 0, "R3");  cd(2.6, 3'd0, 0, "R3");
        // R4: ties away for long-words
        cd(2.5, 3'd0, 1, "R4");  cd(-2.5, 3'd0, 1, "R4"); cd(3.5, 3'd0, 1, "R4");
        // R5: generic convert follows mode field
        wr_sr(32'h0, "R11");     cd(-2.5, 3'd4, 0, "R5");
        wr_sr(32'h1, "R11");     cd(2.7, 3'd4, 0, "R5");
        wr_sr(32'h2, "R11");     cd(2.1, 3'd4, 0, "R5");
        wr_sr(32'h3, "R11");     cd(-2.1, 3'd4, 0, "R5");
        cd(1.0e10, 3'd4, 0, "R5");
        wr_sr(32'h0, "R11");
        // R6: range edges and saturation
        cd(2147483647.0, 3'd1, 0, "R6");  cd(2147483648.0, 3'd1, 0, "R6");
        cd(-2147483648.0, 3'd1, 0, "R6"); cd(-2147483648.5, 3'd1, 0, "R6");
        cd(-2147483649.0, 3'd1, 0, "R6"); cd(2147483647.5, 3'd0, 0, "R6");
        cd(2147483646.2, 3'd3, 0, "R6");  cd(9223372036854775808.0, 3'd1, 1, "R6");
        cd(-9223372036854775808.0, 3'd0, 1, "R6"); cd(1.0e300, 3'd2, 1, "R6");
        // R9: invalid cause kept, others refreshed by a clean conversion
        cd(4.0, 3'd1, 0, "R9");
        // R10: flags remain after clean conversions; only a write clears
        cd(8.0, 3'd1, 1, "R10");
        wr_sr(32'h0, "R10");
        // R7: special operands
        conv(64'h7FF8_0000_0000_0000, 1, 0, 3'd1, "R7");
        wr_sr(32'h0, "R7");
        conv(64'h7FF0_0000_0000_0000, 1, 1, 3'd0, "R7");
        conv(64'hFFF0_0000_0000_0000, 1, 0, 3'd2, "R7");
        conv({32'h1234_5678, 32'h7FC0_0000}, 0, 1, 3'd1, "R7");
        conv({32'h0, 32'h7F80_0000}, 0, 0, 3'd3, "R7");
        // R8: denormals and inexact
        wr_sr(32'h0, "R8");
        conv(64'h0000_0000_0000_0001, 1, 0, 3'd3, "R8");
        conv(64'h0000_0000_0000_0001, 1, 0, 3'd2, "R8");
        conv(64'h8000_0000_0000_0001, 1, 1, 3'd2, "R8");
        // R12: layout, divide-by-zero cause survives conversions
        wr_sr(32'h0001_F07C, "R12");
        cd(1.0, 3'd1, 0, "R12");
        // R11: write wins over a same-cycle update; old mode used
        wr_sr(32'h1, "R11");
        in_opnd = $realtobits(2.5); in_dbl = 1; in_long = 1; in_op = 3'd4;
        in_valid = 1'b1; sr_wr = 1'b1; sr_wdata = 32'h2; cur_tag = "R11";
        @(negedge clk);
        in_valid = 1'b0; sr_wr = 1'b0;
        @(negedge clk);
        // R13: binary32 operands with junk above
        conv({32'hDEAD_BEEF, 32'h4020_0000}, 0, 0, 3'd0, "R13");
        conv({32'hFFFF_FFFF, 32'hBFE0_0000}, 0, 1, 3'd2, "R13");
        conv({32'h0000_0001, 32'h4F00_0000}, 0, 0, 3'd1, "R13");
        repeat (3) @(negedge clk);            // R1 hold over idle cycles
        done = 1'b1;
        report();
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL R1 watchdog act=hung exp=finished");
            report();
            $finish;
        end
    end
endmodule